// File: doc/BRIEF.md
# Serial Frame Alignment and Lock Detector

This block sits behind the bit sampler of a serial receiver whose frames carry their own clock. Each frame is twelve bit periods long: a marker slot driven high, ten payload bits, and a marker slot driven low. The low marker at the end of one frame and the high marker at the start of the next give at least one edge on the line in every frame. The block takes one bit whenever the bit enable is high. It looks for the marker pair at one fixed offset. It reports lock once that offset has held for several frames in a row. From then on it hands each recovered word to the parallel side, together with a one-cycle strobe.

During start-up the transmitter sends training frames whose ten payload bits are all zero. This gives one unique marker position in the stream. If the markers fail for several frames in a row, the block drops lock and searches again. A timeout flag rises if no lock is found within a set number of frame periods. A receiver enable blanks the parallel outputs without disturbing alignment. Powerdown returns everything to the reset state.

Top module: `edc_lock_detector`

## Requirements
- R1: A frame is 12 slots in arrival order: slot 0 is a 1 marker, slots 1 to 10 are payload bits D0 to D9 (LSB first), and slot 11 is a 0 marker. A bit is taken only at a clock edge where `bit_en` is high. Cycles with `bit_en` low change nothing, whatever `bit_in` is.
- R2: While searching, a 12-bit window is judged each time the slot counter reaches its last slot. The window is good when its oldest bit is 1 and its newest bit is 0. When the window is bad, the next window judged is the one that ends one bit later. After reset or powerdown, the first window judged ends on the 12th bit taken.
- R3: `lock` rises at the edge that takes the last bit of the 4th good window in a row at the same offset. Training frames preceded by any number of 0 bits therefore lock at the end of the 4th training frame.
- R4: While locked, each good frame raises `word_stb` for exactly one cycle, at the edge that takes its slot 11. `data_out` then shows that frame's payload with D0 in bit 0 and holds it until the next good frame. No strobe is produced while unlocked, and none for the frame that completes the lock.
- R5: While locked, a frame with a bad marker pair produces no strobe. The 4th bad frame in a row clears `lock`, and a good frame in between restarts that count.
- R6: After losing lock the search restarts, and the block locks again on training frames.
- R7: With `rx_en` low, `data_out` reads 0 and `word_stb` stays low. `lock`, alignment and word capture carry on, so a word captured while disabled appears once `rx_en` returns high.
- R8: With `pwrdn` high, `lock`, `word_stb`, `data_out` and `timeout` are 0 from the next edge, and incoming bits are ignored. After release the search starts from an empty window.
- R9: `timeout` rises when 1024 × 12 bit enables have been counted while unlocked, counting from reset, powerdown or the last time lock was held. It stays high until lock is held.
- R10: After reset `lock`, `word_stb`, `data_out` and `timeout` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| bit_in | input | 1 | Received serial bit |
| bit_en | input | 1 | High for one cycle per bit period |
| rx_en | input | 1 | Parallel output enable |
| pwrdn | input | 1 | Powerdown, holds the block in its reset state |
| data_out | output | 10 | Recovered payload word, 0 while disabled |
| word_stb | output | 1 | One-cycle strobe per recovered word |
| lock | output | 1 | Frame alignment held |
| timeout | output | 1 | No lock within the timeout window |

## Verification
On every cycle the assertions check the following: the slot counter stays in range and only advances on a bit enable, a strobe only appears while lock is held and never on two cycles in a row, lock only rises on a bit enable, and powerdown clears lock and strobe. They also check that the timeout counter is idle while locked and that the flag is sticky while unlocked. Only the directed scenarios can show the values that matter: the frame on which lock rises from an unknown offset, the payload bit order, the tolerance of three bad frames and loss on the fourth, relock after a false match, blanking under the output enable, and the exact bit count at which the timeout rises.

// File: rtl/edc_pkg.sv
package edc_pkg;
    typedef enum logic {
        MODE_HUNT   = 1'b0,
        MODE_LOCKED = 1'b1
    } edc_mode_e;
endpackage

// File: rtl/edc_frame_window.sv
module edc_frame_window #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwrdn,
    input  logic              bit_en,
    input  logic              bit_in,
    output logic              frame_ok,
    output logic [DATA_W-1:0] payload
);
    localparam int SLOTS = DATA_W + 2;

    typedef struct packed {
        logic [SLOTS-1:0] sh;
    } win_st_t;

    win_st_t st_d, st_q;
    logic [SLOTS-1:0] win;

    // Newest bit enters at the top; the oldest (start marker) sits at bit 0.
    always_comb begin
        win      = {bit_in, st_q.sh[SLOTS-1:1]};
        frame_ok = win[0] & ~win[SLOTS-1];
        payload  = win[SLOTS-2:1];
        st_d     = st_q;
        if (pwrdn) begin
            st_d = '0;
        end else if (bit_en) begin
            st_d.sh = win;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R1: no bit enters the window without an enable
    p_window_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !pwrdn) |=> $stable(st_q.sh));
endmodule

// File: rtl/edc_align_fsm.sv
module edc_align_fsm
    import edc_pkg::*;
#(
    parameter int DATA_W      = 10,
    parameter int GOOD_FRAMES = 4,
    parameter int BAD_FRAMES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwrdn,
    input  logic              bit_en,
    input  logic              frame_ok,
    input  logic [DATA_W-1:0] payload,
    output logic              lock,
    output logic              stb,
    output logic [DATA_W-1:0] word
);
    localparam int SLOTS = DATA_W + 2;
    localparam int PH_W  = $clog2(SLOTS);
    localparam int GC_W  = $clog2(GOOD_FRAMES + 1);
    localparam int BC_W  = $clog2(BAD_FRAMES + 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOTS - 1);

    typedef struct packed {
        edc_mode_e         mode;
        logic [PH_W-1:0]   phase;
        logic [GC_W-1:0]   good_cnt;
        logic [BC_W-1:0]   bad_cnt;
        logic              stb;
        logic [DATA_W-1:0] word;
    } align_st_t;

    align_st_t st_d, st_q;
    logic      frame_end;

    always_comb begin
        st_d      = st_q;
        st_d.stb  = 1'b0;
        frame_end = bit_en && (st_q.phase == PH_LAST);
        if (pwrdn) begin
            st_d = '0;
        end else if (bit_en && !frame_end) begin
            st_d.phase = st_q.phase + PH_W'(1);
        end else if (frame_end) begin
            if (st_q.mode == MODE_HUNT) begin
                if (frame_ok) begin
                    st_d.phase = '0;
                    if (st_q.good_cnt == GC_W'(GOOD_FRAMES - 1)) begin
                        st_d.mode     = MODE_LOCKED;
                        st_d.good_cnt = '0;
                        st_d.bad_cnt  = '0;
                    end else begin
                        st_d.good_cnt = st_q.good_cnt + GC_W'(1);
                    end
                end else begin
                    // slip: stay on the last slot so the next bit is judged
                    st_d.good_cnt = '0;
                end
            end else begin
                if (frame_ok) begin
                    st_d.phase   = '0;
                    st_d.bad_cnt = '0;
                    st_d.stb     = 1'b1;
                    st_d.word    = payload;
                end else if (st_q.bad_cnt == BC_W'(BAD_FRAMES - 1)) begin
                    st_d.mode     = MODE_HUNT;
                    st_d.bad_cnt  = '0;
                    st_d.good_cnt = '0;
                end else begin
                    st_d.phase   = '0;
                    st_d.bad_cnt = st_q.bad_cnt + BC_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lock = (st_q.mode == MODE_LOCKED);
    assign stb  = st_q.stb;
    assign word = st_q.word;

    p_phase_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase <= PH_LAST);
    p_phase_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && !pwrdn) |=> ($stable(st_q.phase) && !st_q.stb));
    p_lock_on_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(bit_en));
    p_strobe_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stb |-> (lock && $past(lock)));
    p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.stb |=> !st_q.stb);
    p_bad_count_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bad_cnt < BC_W'(BAD_FRAMES));
    p_pwrdn_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwrdn |=> (!lock && !st_q.stb && st_q.word == '0));
endmodule

// File: rtl/edc_lock_timer.sv
module edc_lock_timer #(
    parameter int SLOTS          = 12,
    parameter int TIMEOUT_FRAMES = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwrdn,
    input  logic bit_en,
    input  logic lock,
    output logic timeout
);
    localparam int LIMIT = TIMEOUT_FRAMES * SLOTS;
    localparam int CW    = $clog2(LIMIT + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          flag;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pwrdn || lock) begin
            st_d = '0;
        end else if (bit_en && !st_q.flag) begin
            st_d.cnt  = st_q.cnt + CW'(1);
            st_d.flag = (st_d.cnt == CW'(LIMIT));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign timeout = st_q.flag;

    p_timer_idle_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> (st_q.cnt == '0 && !st_q.flag));
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !lock && !pwrdn) |=> st_q.flag);
endmodule

// File: rtl/edc_lock_detector.sv
module edc_lock_detector #(
    parameter int DATA_W         = 10,
    parameter int GOOD_FRAMES    = 4,
    parameter int BAD_FRAMES     = 4,
    parameter int TIMEOUT_FRAMES = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_en,
    input  logic              rx_en,
    input  logic              pwrdn,
    output logic [DATA_W-1:0] data_out,
    output logic              word_stb,
    output logic              lock,
    output logic              timeout
);
    localparam int SLOTS = DATA_W + 2;

    logic              frame_ok;
    logic [DATA_W-1:0] payload;
    logic              stb_raw;
    logic [DATA_W-1:0] word_raw;

    edc_frame_window #(.DATA_W(DATA_W)) win_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwrdn    (pwrdn),
        .bit_en   (bit_en),
        .bit_in   (bit_in),
        .frame_ok (frame_ok),
        .payload  (payload)
    );

    edc_align_fsm #(
        .DATA_W      (DATA_W),
        .GOOD_FRAMES (GOOD_FRAMES),
        .BAD_FRAMES  (BAD_FRAMES)
    ) fsm_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwrdn    (pwrdn),
        .bit_en   (bit_en),
        .frame_ok (frame_ok),
        .payload  (payload),
        .lock     (lock),
        .stb      (stb_raw),
        .word     (word_raw)
    );

    edc_lock_timer #(
        .SLOTS          (SLOTS),
        .TIMEOUT_FRAMES (TIMEOUT_FRAMES)
    ) tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwrdn   (pwrdn),
        .bit_en  (bit_en),
        .lock    (lock),
        .timeout (timeout)
    );

    // Output blanking models a released parallel bus.
    assign word_stb = stb_raw & rx_en;
    assign data_out = rx_en ? word_raw : '0;

    p_steady_lock_no_timeout_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && $past(lock)) |-> !timeout);
endmodule

// File: tb/edc_lock_detector_tb.sv
`timescale 1ns/1ps
module edc_lock_detector_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_in = 1'b0;
    logic       bit_en = 1'b0;
    logic       rx_en = 1'b1;
    logic       pwrdn = 1'b0;
    logic [9:0] data_out;
    logic       word_stb;
    logic       lock;
    logic       timeout;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    edc_lock_detector dut_i (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_en(bit_en),
        .rx_en(rx_en), .pwrdn(pwrdn), .data_out(data_out),
        .word_stb(word_stb), .lock(lock), .timeout(timeout)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input int gaps);
        for (int g = 0; g < gaps; g++) begin
            @(negedge clk); bit_en = 1'b0; bit_in = ~b;
        end
        @(negedge clk); bit_in = b; bit_en = 1'b1;
    endtask

    // Sends one frame and returns at the negedge after its last bit.
    task automatic send_frame(input logic st, input logic [9:0] w, input logic sp, input int gaps);
        send_bit(st, gaps);
        for (int i = 0; i < 10; i++) send_bit(w[i], gaps);
        send_bit(sp, gaps);
        @(negedge clk); bit_en = 1'b0;
    endtask

    task automatic pulse_pwrdn();
        @(negedge clk); pwrdn = 1'b1;
        repeat (3) @(negedge clk);
        pwrdn = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 lock", lock, 0);
        check("R10 strobe", word_stb, 0);
        check("R10 data", data_out, 0);
        check("R10 timeout", timeout, 0);
    endtask

    task automatic t_acquire_offset();
        for (int i = 0; i < 5; i++) send_bit(1'b0, 0);
        for (int f = 0; f < 3; f++) begin
            send_frame(1'b1, 10'h000, 1'b0, 0);
            check("R3 no early lock", lock, 0);
            check("R4 no strobe unlocked", word_stb, 0);
        end
        send_frame(1'b1, 10'h000, 1'b0, 0);
        check("R3 lock after 4th frame", lock, 1);
        check("R4 no strobe on locking frame", word_stb, 0);
    endtask

    task automatic t_data();
        logic [9:0] words [5] = '{10'h3A5, 10'h155, 10'h2AA, 10'h001, 10'h200};
        for (int k = 0; k < 5; k++) begin
            send_frame(1'b1, words[k], 1'b0, (k % 2) * 2); // R1 idle cycles ignored
            check("R4 strobe", word_stb, 1);
            check("R1 R4 payload", data_out, words[k]);
            @(negedge clk);
            check("R4 strobe one cycle", word_stb, 0);
            check("R4 data held", data_out, words[k]);
        end
    endtask

    task automatic t_rx_disable();
        @(negedge clk); rx_en = 1'b0;
        send_frame(1'b1, 10'h2C3, 1'b0, 0);
        check("R7 strobe blanked", word_stb, 0);
        check("R7 data blanked", data_out, 0);
        check("R7 lock kept", lock, 1);
        rx_en = 1'b1;
        #1;
        check("R7 word captured while disabled", data_out, 10'h2C3);
    endtask

    task automatic t_loss();
        for (int f = 0; f < 3; f++) begin
            send_frame(1'b1, 10'h000, 1'b1, 0);
            check("R5 no strobe bad frame", word_stb, 0);
            check("R5 lock held", lock, 1);
        end
        send_frame(1'b1, 10'h0F0, 1'b0, 0);
        check("R5 good frame strobes", word_stb, 1);
        check("R5 good frame data", data_out, 10'h0F0);
        for (int f = 0; f < 3; f++) begin
            send_frame(1'b1, 10'h000, 1'b1, 0);
            check("R5 count restarted", lock, 1);
        end
        send_frame(1'b1, 10'h000, 1'b1, 0);
        check("R5 lock lost on 4th bad", lock, 0);
        for (int f = 0; f < 6; f++) send_frame(1'b1, 10'h000, 1'b0, 0);
        check("R6 relock", lock, 1);
    endtask

    task automatic t_powerdown();
        @(negedge clk); pwrdn = 1'b1;
        @(negedge clk);
        check("R8 lock cleared", lock, 0);
        check("R8 strobe low", word_stb, 0);
        check("R8 data cleared", data_out, 0);
        for (int f = 0; f < 5; f++) send_frame(1'b1, 10'h000, 1'b0, 0);
        check("R8 bits ignored", lock, 0);
        pwrdn = 1'b0;
        for (int f = 0; f < 3; f++) send_frame(1'b1, 10'h000, 1'b0, 0);
        check("R8 fresh search no early lock", lock, 0);
        send_frame(1'b1, 10'h000, 1'b0, 0);
        check("R8 fresh search locks", lock, 1);
    endtask

    task automatic t_timeout();
        pulse_pwrdn();
        check("R8 timeout cleared", timeout, 0);
        for (int i = 0; i < 12287; i++) begin
            @(negedge clk); bit_in = 1'b0; bit_en = 1'b1;
        end
        @(negedge clk); bit_en = 1'b0;
        check("R9 no timeout one short", timeout, 0);
        send_bit(1'b0, 0);
        @(negedge clk); bit_en = 1'b0;
        check("R9 timeout at limit", timeout, 1);
        for (int f = 0; f < 4; f++) send_frame(1'b1, 10'h000, 1'b0, 0);
        check("R9 lock after timeout", lock, 1);
        send_frame(1'b1, 10'h000, 1'b0, 0);
        check("R9 timeout cleared by lock", timeout, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_acquire_offset();
        t_data();
        t_rx_disable();
        t_loss();
        t_powerdown();
        t_timeout();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule